// File: doc/BRIEF.md
# Programmable Clock Output Controller

This block sits behind an analog frequency synthesizer and turns its raw clocks into the two clocks a board sees. It receives a reference clock and an already-generated oscillator clock, divides them with an even post-divider, and routes the results to a main clock output and to a multi-role pad. All clock signals are handled as oversampled levels in the block's own `clk` domain. Each rising edge of a clock input is found by comparing the input with its value one `clk` cycle earlier, and every divider advances only on such an edge.

Two stored profiles each hold a post-divider value and a source choice for each of the two outputs. A small register-write port loads them, together with the pad role and an exported drive-strength code, and stands in for one-time-programmable storage. The pad can serve as an output-enable input, a sleep input, a profile-select input, or a second clock output. When it is an input and nothing drives it, a weak pull-up makes it read as 1. A change of profile reaches the outputs only at a rising edge of the post-divided oscillator clock.

Top module: `clkctl_top`

## Requirements
- R1: With active divider value P (1..31), the post-divided oscillator clock stays high for P oscillator rising edges and then low for P oscillator rising edges, so it divides by 2×P with 50% duty.
- R2: A stored divider value of 0 behaves exactly like a value of 1 (divide by 2), so the divided clock never stalls.
- R3: The main-output source code selects the main clock: 0 is the post-divided oscillator, 1 is the reference delayed by one `clk` cycle, 2 is the reference divided by 2×P, and 3 behaves like 0.
- R4: In pad role 3 the pad drives (`pad_oe`=1) the second clock, selected by code: 0 is the reference delayed by one `clk` cycle, 1 is the reference divided by 2, 2 is the main clock, and 3 is the main clock divided by 2. In any other role, `pad_oe` and `pad_o` are 0.
- R5: In pad role 0 (output enable), a low pad level forces `clk0_oe` to 0 in the same cycle and a high level gives 1. In every other role `clk0_oe` is 1.
- R6: In pad role 1 (sleep), a low pad level clears every divider and holds `clk0_o` and `pad_o` at 0. After release, every divider restarts from a zero count and a low output.
- R7: In pad role 2 (profile select), a high pad level selects profile 1 and a low level selects profile 2. In every other role profile 1 is selected.
- R8: When `pad_drv` is 0, the pad reads as logic 1 in every input role.
- R9: The active profile (divider value and both source codes) is reloaded from the selected stored profile only at the `clk` edge where the post-divided oscillator clock rises. Writes and profile selection have no effect on the outputs before that edge.
- R10: On a write, `cfg_addr` picks the field. Address 0 holds the divider value of profile 1 and address 2 that of profile 2, both in `cfg_wdata[P_W-1:0]`. Addresses 1 and 3 hold the source codes of profiles 1 and 2, with the main source in `[1:0]` and the second source in `[3:2]`. Address 4 holds the pad role in `[1:0]` and the drive code in `[3:2]`, which appears on `drive_o` one cycle after the write. After reset both profiles hold divider 1 and source codes 0, the role is 0, and the drive code is 1 (standard), with 0 meaning low and 2 meaning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock level |
| osc_i | input | 1 | Oscillator clock level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration field address |
| cfg_wdata | input | 8 | Configuration write data |
| pad_i | input | 1 | Level seen on the multi-role pad |
| pad_drv | input | 1 | 1 when something external drives the pad |
| pad_o | output | 1 | Second clock driven onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| clk0_o | output | 1 | Main clock output |
| clk0_oe | output | 1 | Main clock driver enable (0 = high impedance) |
| drive_o | output | 2 | Stored drive-strength code |

## Verification
A divider counter in a wrong state shows at once as a high or low phase of the wrong length on `clk0_o` or `pad_o`, seen at the next input edge that should have toggled it. A stale or early active profile shows as a source switch or period change one cycle away from a rising edge of the divided oscillator clock. A missed sleep clear shows as a non-zero first phase after release. Because the reference model is compared with every output on every cycle, each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [1:0] {
      C0_OSC_DIV = 2'd0,
      C0_REF_RAW = 2'd1,
      C0_REF_DIV = 2'd2,
      C0_SPARE   = 2'd3
   } c0_src_e;

   typedef enum logic [1:0] {
      C1_REF_RAW  = 2'd0,
      C1_REF_HALF = 2'd1,
      C1_MAIN     = 2'd2,
      C1_MAIN_HALF = 2'd3
   } c1_src_e;

   typedef enum logic [1:0] {
      ROLE_ENABLE = 2'd0,
      ROLE_SLEEP  = 2'd1,
      ROLE_PSEL   = 2'd2,
      ROLE_CLKOUT = 2'd3
   } pin_role_e;

   localparam logic [1:0] DRIVE_STD   = 2'd1;
   localparam int         NUM_PROF    = 2;
   localparam int         CFG_AW      = 3;
   localparam int         CFG_DW      = 8;
   localparam logic [CFG_AW-1:0] ADDR_MISC = 3'd4;

endpackage

// File: rtl/clkctl_div.sv
module clkctl_div #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] lim,
   output logic          q,
   output logic          wrap_up
);

   logic [CW-1:0] cnt;
   logic          hit;

   assign hit     = (cnt >= lim - 1'b1);
   assign wrap_up = !clr && tick && hit && !q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (tick) begin
         if (hit) begin
            cnt <= '0;
            q   <= !q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R1: the divided level only moves on an input edge or a clear
   p_div_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(q));

   // R6: a clear leaves the divider low and at count zero
   p_div_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!q && cnt == '0));

endmodule

// File: rtl/clkctl_cfg.sv
module clkctl_cfg
   import clkctl_pkg::*;
#(
   parameter int P_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_AW-1:0] addr,
   input  logic [CFG_DW-1:0] wdata,
   input  logic              use_p2,
   output logic [P_W-1:0]    sel_p,
   output c0_src_e           sel_c0,
   output c1_src_e           sel_c1,
   output pin_role_e         role,
   output logic [1:0]        drive
);

   logic [P_W-1:0] prof_p  [NUM_PROF];
   c0_src_e        prof_c0 [NUM_PROF];
   c1_src_e        prof_c1 [NUM_PROF];

   for (genvar gi = 0; gi < NUM_PROF; gi++) begin : g_prof
      localparam logic [CFG_AW-1:0] A_DIV = CFG_AW'(2 * gi);
      localparam logic [CFG_AW-1:0] A_SRC = CFG_AW'(2 * gi + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prof_p[gi]  <= P_W'(1);
            prof_c0[gi] <= C0_OSC_DIV;
            prof_c1[gi] <= C1_REF_RAW;
         end else if (we) begin
            if (addr == A_DIV) prof_p[gi] <= wdata[P_W-1:0];
            if (addr == A_SRC) begin
               prof_c0[gi] <= c0_src_e'(wdata[1:0]);
               prof_c1[gi] <= c1_src_e'(wdata[3:2]);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         role  <= ROLE_ENABLE;
         drive <= DRIVE_STD;
      end else if (we && addr == ADDR_MISC) begin
         role  <= pin_role_e'(wdata[1:0]);
         drive <= wdata[3:2];
      end
   end

   assign sel_p  = use_p2 ? prof_p[1]  : prof_p[0];
   assign sel_c0 = use_p2 ? prof_c0[1] : prof_c0[0];
   assign sel_c1 = use_p2 ? prof_c1[1] : prof_c1[0];

   // R10: drive code written at the misc address shows up next cycle
   p_drive_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_MISC) |=> (drive == $past(wdata[3:2])));

endmodule

// File: rtl/clkctl_route.sv
module clkctl_route
   import clkctl_pkg::*;
(
   input  logic      run,
   input  pin_role_e role,
   input  c0_src_e   c0_sel,
   input  c1_src_e   c1_sel,
   input  logic      osc_div,
   input  logic      ref_raw,
   input  logic      ref_div,
   input  logic      ref_half,
   input  logic      main_half,
   output logic      main_clk,
   output logic      side_clk,
   output logic      side_oe
);

   always_comb begin
      main_clk = 1'b0;
      if (run) begin
         unique case (c0_sel)
            C0_REF_RAW: main_clk = ref_raw;
            C0_REF_DIV: main_clk = ref_div;
            default:    main_clk = osc_div;
         endcase
      end
   end

   always_comb begin
      side_oe  = (role == ROLE_CLKOUT);
      side_clk = 1'b0;
      if (side_oe) begin
         unique case (c1_sel)
            C1_REF_RAW:  side_clk = ref_raw;
            C1_REF_HALF: side_clk = ref_half;
            C1_MAIN:     side_clk = main_clk;
            default:     side_clk = main_half;
         endcase
      end
   end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
   import clkctl_pkg::*;
#(
   parameter int P_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_i,
   input  logic              osc_i,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              pad_i,
   input  logic              pad_drv,
   output logic              pad_o,
   output logic              pad_oe,
   output logic              clk0_o,
   output logic              clk0_oe,
   output logic [1:0]        drive_o
);

   if (P_W < 2 || P_W > CFG_DW) begin : g_bad_width
      $error("clkctl_top: P_W must lie between 2 and the write data width");
   end

   localparam logic [P_W-1:0] LIM_ONE = P_W'(1);

   logic           pin_lvl, run, use_p2;
   pin_role_e      role;
   logic [P_W-1:0] sel_p, act_p, eff_p;
   c0_src_e        sel_c0, act_c0;
   c1_src_e        sel_c1, act_c1;
   logic           ref_d, osc_d, main_d;
   logic           ref_tick, osc_tick, main_tick;
   logic           osc_q, ref_q, refh_q, mainh_q;
   logic           osc_wrap, ref_wrap_unused, refh_wrap_unused, mainh_wrap_unused;
   logic           main_clk;

   assign pin_lvl = pad_drv ? pad_i : 1'b1;
   assign run     = !(role == ROLE_SLEEP && !pin_lvl);
   assign use_p2  = (role == ROLE_PSEL) && !pin_lvl;
   assign clk0_oe = !(role == ROLE_ENABLE && !pin_lvl);
   assign eff_p   = (act_p == '0) ? LIM_ONE : act_p;

   clkctl_cfg #(.P_W(P_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .use_p2(use_p2), .sel_p(sel_p), .sel_c0(sel_c0), .sel_c1(sel_c1),
      .role(role), .drive(drive_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_d  <= 1'b0;
         osc_d  <= 1'b0;
         main_d <= 1'b0;
      end else begin
         ref_d  <= ref_i;
         osc_d  <= osc_i;
         main_d <= clk0_o;
      end
   end

   assign ref_tick  = ref_i && !ref_d;
   assign osc_tick  = osc_i && !osc_d;
   assign main_tick = clk0_o && !main_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_p  <= LIM_ONE;
         act_c0 <= C0_OSC_DIV;
         act_c1 <= C1_REF_RAW;
      end else if (osc_wrap) begin
         act_p  <= sel_p;
         act_c0 <= sel_c0;
         act_c1 <= sel_c1;
      end
   end

   clkctl_div #(.CW(P_W)) u_osc_div (
      .clk(clk), .rst_n(rst_n), .clr(!run), .tick(osc_tick), .lim(eff_p),
      .q(osc_q), .wrap_up(osc_wrap));

   clkctl_div #(.CW(P_W)) u_ref_div (
      .clk(clk), .rst_n(rst_n), .clr(!run), .tick(ref_tick), .lim(eff_p),
      .q(ref_q), .wrap_up(ref_wrap_unused));

   clkctl_div #(.CW(P_W)) u_ref_half (
      .clk(clk), .rst_n(rst_n), .clr(!run), .tick(ref_tick), .lim(LIM_ONE),
      .q(refh_q), .wrap_up(refh_wrap_unused));

   clkctl_div #(.CW(P_W)) u_main_half (
      .clk(clk), .rst_n(rst_n), .clr(!run), .tick(main_tick), .lim(LIM_ONE),
      .q(mainh_q), .wrap_up(mainh_wrap_unused));

   clkctl_route u_route (
      .run(run), .role(role), .c0_sel(act_c0), .c1_sel(act_c1),
      .osc_div(osc_q), .ref_raw(ref_d), .ref_div(ref_q), .ref_half(refh_q),
      .main_half(mainh_q), .main_clk(main_clk), .side_clk(pad_o), .side_oe(pad_oe));

   assign clk0_o = main_clk;

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^cfg_wdata;

   // R6: while asleep the dividers are held at zero
   p_sleep_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!osc_q && !ref_q && !refh_q && !mainh_q));

   // R9: the active profile changes only together with a rise of the divided oscillator
   p_switch_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_p) || !$stable(act_c0) || !$stable(act_c1)) |-> $rose(osc_q));

endmodule

// File: tb/tb_clkctl_top.sv
`timescale 1ns/1ps
module tb_clkctl_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_i = 1'b0, osc_i = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       pad_i = 1'b1, pad_drv = 1'b0;
   logic       pad_o, pad_oe, clk0_o, clk0_oe;
   logic [1:0] drive_o;

   int checks = 0, errors = 0, cyc = 0;
   string tag = "R10";
   bit done = 0;

   always #2 clk = ~clk;

   clkctl_top dut (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .osc_i(osc_i),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pad_i(pad_i), .pad_drv(pad_drv), .pad_o(pad_o), .pad_oe(pad_oe),
      .clk0_o(clk0_o), .clk0_oe(clk0_oe), .drive_o(drive_o));

   // ---------------- behavioural reference model ----------------
   int m_p[2], m_c0[2], m_c1[2], m_role, m_drv;
   int a_p, a_c0, a_c1, co, cr;
   bit refd, oscd, c0d, qo, qr, hr, h0;

   function automatic bit pin_v();
      return pad_drv ? pad_i : 1'b1;
   endfunction
   function automatic bit m_run();
      return !(m_role == 1 && !pin_v());
   endfunction
   function automatic bit m_main();
      if (!m_run()) return 1'b0;
      if (a_c0 == 1) return refd;
      if (a_c0 == 2) return qr;
      return qo;
   endfunction
   function automatic bit m_side();
      if (m_role != 3) return 1'b0;
      case (a_c1)
         0: return refd;
         1: return hr;
         2: return m_main();
         default: return h0;
      endcase
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 2; i++) begin m_p[i] = 1; m_c0[i] = 0; m_c1[i] = 0; end
      m_role = 0; m_drv = 1;
      a_p = 1; a_c0 = 0; a_c1 = 0; co = 0; cr = 0;
      refd = 0; oscd = 0; c0d = 0; qo = 0; qr = 0; hr = 0; h0 = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         bit c0, rn, rr, orr;
         int s, lim, np, n0, n1;
         c0 = m_main(); rn = m_run();
         s = (m_role == 2 && !pin_v()) ? 1 : 0;
         rr = ref_i && !refd; orr = osc_i && !oscd;
         lim = (a_p == 0) ? 1 : a_p;
         np = a_p; n0 = a_c0; n1 = a_c1;
         if (!rn) begin
            co = 0; cr = 0; qo = 0; qr = 0; hr = 0; h0 = 0;
         end else begin
            if (orr) begin
               if (co >= lim - 1) begin
                  co = 0;
                  if (!qo) begin np = m_p[s]; n0 = m_c0[s]; n1 = m_c1[s]; end
                  qo = !qo;
               end else co++;
            end
            if (rr) begin
               if (cr >= lim - 1) begin cr = 0; qr = !qr; end else cr++;
               hr = !hr;
            end
            if (c0 && !c0d) h0 = !h0;
         end
         c0d = c0; refd = ref_i; oscd = osc_i;
         a_p = np; a_c0 = n0; a_c1 = n1;
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: m_p[0] = cfg_wdata[4:0];
               3'd1: begin m_c0[0] = cfg_wdata[1:0]; m_c1[0] = cfg_wdata[3:2]; end
               3'd2: m_p[1] = cfg_wdata[4:0];
               3'd3: begin m_c0[1] = cfg_wdata[1:0]; m_c1[1] = cfg_wdata[3:2]; end
               3'd4: begin m_role = cfg_wdata[1:0]; m_drv = cfg_wdata[3:2]; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // every-cycle comparison, tagged with the requirement under test
   always @(posedge clk) begin
      cyc++;
      #1;
      if (rst_n && !done) begin
         chk(tag, "clk0_o",  clk0_o,  m_main());
         chk(tag, "clk0_oe", clk0_oe, !(m_role == 0 && !pin_v()));
         chk(tag, "pad_oe",  pad_oe,  m_role == 3);
         chk(tag, "pad_o",   pad_o,   m_side());
         chk(tag, "drive_o", drive_o, m_drv);
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // clock-level stimulus: reference toggles every 3 cycles, oscillator every 2
   initial begin
      int rc = 0, oc = 0;
      forever begin
         @(negedge clk);
         rc++; oc++;
         if (rc == 3) begin rc = 0; ref_i = !ref_i; end
         if (oc == 2) begin oc = 0; osc_i = !osc_i; end
      end
   end

   task automatic cfg(int a, int d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a[2:0]; cfg_wdata = d[7:0];
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_rises(int n, output int k);
      bit prev;
      k = 0;
      @(posedge clk); #1; prev = clk0_o;
      repeat (n) begin
         @(posedge clk); #1;
         if (clk0_o && !prev) k++;
         prev = clk0_o;
      end
   endtask

   task automatic near(string req, string what, int act, int exp);
      checks++;
      if (act < exp - 1 || act > exp + 1) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      int k;
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      chk("R10", "reset drive", drive_o, 1);
      chk("R5", "reset clk0_oe", clk0_oe, 1);
      chk("R4", "reset pad_oe", pad_oe, 0);
      chk("R10", "reset clk0_o", clk0_o, 0);

      tag = "R1";
      cfg(0, 3); cfg(1, 0); idle(200);
      count_rises(240, k); near("R1", "rises in 240 cycles, P=3", k, 10);

      tag = "R2";
      cfg(0, 0); idle(40);
      count_rises(160, k); near("R2", "rises in 160 cycles, P=0", k, 20);

      tag = "R3";
      cfg(0, 2);
      cfg(1, 1); idle(100);
      cfg(1, 2); idle(150);
      cfg(1, 3); idle(100);

      tag = "R4";
      cfg(4, 8'h07);
      for (int c = 0; c < 4; c++) begin cfg(1, c << 2); idle(120); end
      @(posedge clk); #1; chk("R4", "pad_oe in clock role", pad_oe, 1);

      tag = "R5";
      cfg(4, 8'h04); pad_drv = 1; pad_i = 0; idle(2);
      @(posedge clk); #1; chk("R5", "clk0_oe with pad low", clk0_oe, 0);
      idle(30); pad_i = 1; idle(30);

      tag = "R6";
      cfg(0, 3); cfg(1, 0); cfg(4, 8'h05); idle(40);
      pad_i = 0; idle(50);
      @(posedge clk); #1; chk("R6", "clk0_o asleep", clk0_o, 0);
      @(negedge clk); pad_i = 1;
      @(posedge clk); #1; chk("R6", "clk0_o right after wake", clk0_o, 0);
      idle(150);

      tag = "R7";
      cfg(2, 5); cfg(3, 8'h06); cfg(4, 8'h06);
      idle(100); pad_i = 0; idle(250); pad_i = 1; idle(100);

      tag = "R8";
      pad_drv = 0; pad_i = 0; idle(150);
      cfg(4, 8'h04); idle(3);
      @(posedge clk); #1; chk("R8", "clk0_oe with pad undriven", clk0_oe, 1);

      tag = "R9";
      cfg(0, 12); cfg(1, 0); cfg(4, 8'h06); pad_drv = 1; pad_i = 1; idle(150);
      pad_i = 0; idle(200); cfg(2, 2); idle(100); pad_i = 1; idle(200);

      tag = "R10";
      cfg(4, 8'h08);
      @(posedge clk); #1; chk("R10", "drive after write", drive_o, 2);
      cfg(5, 8'hff); idle(20);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule